// File: doc/BRIEF.md
# Byte-to-Word Frame Stream Packer

This block takes an Ethernet frame presented one byte at a time, with a start marker on the first byte and an end marker on the last, and packs it into 32-bit words for the transmit FIFO of a MAC. The output is a valid/ready word stream with start-of-packet, end-of-packet and a 2-bit empty count. Bytes are packed big-endian, so the earliest byte sits in the most significant lane. A whole frame leaves as one stream packet, with the start marker on its first word and the end marker on its last.

Some MACs throw away the upper 16 bits of the first word of a frame. For those, a pad mode puts two filler bytes in front of the frame, so that the first real byte lands in bits 15:8 of the first word and nothing real is lost. The mode is sampled on the byte that starts each frame.

A frame whose length does not fill the last word is closed off as soon as its end byte arrives. The empty count then says how many trailing lanes of that word hold no data. Downstream backpressure stalls the byte input, and no byte is lost or reordered.

Top module: `byte_word_packer`

## Requirements
- R1: Bytes are packed most significant lane first: the bytes 11 22 33 44 of a frame give the word 0x11223344.
- R2: A frame leaves as one packet of consecutive words. `out_sop` is 1 only on its first word and `out_eop` only on its last.
- R3: On the end word, `out_empty` equals the number of unused trailing byte lanes, (4 - L mod 4) mod 4 for a frame of L bytes, and those lanes read zero. On every other word `out_empty` is 0.
- R4: When `pad_en` is 1 on the start byte, bits 31:16 of the first word are zero and the first frame byte sits in bits 15:8. Later bytes follow big-endian, and `out_empty` is computed from L + 2.
- R5: A frame of at most 4 bytes, or at most 2 bytes in pad mode, gives a single word with `out_sop` and `out_eop` both 1.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_sop`, `out_eop` and `out_empty` hold their values. Under any pattern of `out_ready`, the word sequence is unchanged.
- R7: `in_ready` is 0 whenever `out_valid` is 1 and `out_ready` is 0.
- R8: When the end byte of a frame is accepted at a clock edge, the word that closes the frame is presented on the output right after that same edge.
- R9: While `rst_n` is low, `out_valid` is cleared and any partly built word and lane position are discarded. A frame that starts after reset is packed as if nothing came before it.
- R10: A byte accepted outside a frame, meaning after an end byte and before the next start byte, is dropped and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pad_en | input | 1 | Reserve two leading filler bytes; sampled with the start byte |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Packed word, earliest byte in bits 31:24 |
| out_sop | output | 1 | First word of a frame |
| out_eop | output | 1 | Last word of a frame |
| out_empty | output | 2 | Unused trailing lanes on the end word |

## Verification
The packet-framing assertions assume that every frame at the input begins with a byte that has `in_sof` set and ends with one that has `in_eof` set, and that no frame starts before the previous one has ended. Only then does every output word after an end word carry a start marker. The directed stimulus always sends frames whole, in that form. The one exception is the stray-byte test, and there the stray bytes are dropped, so they never reach the output. The hold assertions place no limit on `out_ready`, and the bench drives it as always high, as a periodic pattern and as long stall runs.

// File: rtl/pkt_pkg.sv
// Shared constants and helpers for the byte-to-word packer.
// Assumes the lane count is a power of two and at least two.
package pkt_pkg;
    localparam int BYTE_W_DEF   = 8;
    localparam int LANES_DEF    = 4;
    localparam int PAD_LANES_DEF = 2;

    // Bit position of the least significant bit of lane l, where lane 0 is the most significant.
    function automatic int lane_lsb(input int l, input int lanes, input int bw);
        return (lanes - 1 - l) * bw;
    endfunction
endpackage

// File: rtl/pkt_lane_asm.sv
// Lane assembler: places each accepted byte into its lane of a partial word and
// signals a push when the word is complete or the frame ends.
// Assumes the caller only asserts take when the output slot can load a word.
module pkt_lane_asm #(
    parameter int BYTE_W    = pkt_pkg::BYTE_W_DEF,
    parameter int LANES     = pkt_pkg::LANES_DEF,
    parameter int PAD_LANES = pkt_pkg::PAD_LANES_DEF,
    localparam int WORD_W   = LANES * BYTE_W,
    localparam int LW       = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pad_en,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              sof_i,
    input  logic              eof_i,
    output logic              push,
    output logic [WORD_W-1:0] word_o,
    output logic              sop_o,
    output logic              eop_o,
    output logic [LW-1:0]     empty_o
);
    logic [WORD_W-1:0] acc_q;
    logic [LW-1:0]     lane_q;
    logic              first_q;
    logic              in_frame_q;

    logic [LW-1:0]     pos;
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] merged;
    logic              live;

    // Lane for this byte: a start byte restarts at lane 0 or after the pad.
    always_comb begin
        pos  = sof_i ? (pad_en ? LW'(PAD_LANES) : '0) : lane_q;
        base = sof_i ? '0 : acc_q;
        live = sof_i | in_frame_q;
    end

    // One lane slot per byte position, filled from the byte or the held partial word.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int LSB = pkt_pkg::lane_lsb(l, LANES, BYTE_W);
        assign merged[LSB +: BYTE_W] = (pos == LW'(l)) ? byte_i : base[LSB +: BYTE_W];
    end

    // Word completion and its framing fields.
    always_comb begin
        push    = take & live & ((pos == LW'(LANES - 1)) | eof_i);
        word_o  = merged;
        sop_o   = sof_i | first_q;
        eop_o   = eof_i;
        empty_o = eof_i ? (LW'(LANES - 1) - pos) : '0;
    end

    // Partial word, lane position and frame state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            lane_q     <= '0;
            first_q    <= 1'b0;
            in_frame_q <= 1'b0;
        end else if (take && live) begin
            if (push) begin
                acc_q      <= '0;
                lane_q     <= '0;
                first_q    <= 1'b0;
                in_frame_q <= ~eof_i;
            end else begin
                acc_q      <= merged;
                lane_q     <= pos + LW'(1);
                first_q    <= sof_i | first_q;
                in_frame_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pkt_out_reg.sv
// Output word register with a valid/ready handshake; holds its contents while stalled.
// Assumes load is only asserted when slot_free is high.
module pkt_out_reg #(
    parameter int WORD_W  = 32,
    parameter int EMPTY_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [WORD_W-1:0]  d_data,
    input  logic               d_sop,
    input  logic               d_eop,
    input  logic [EMPTY_W-1:0] d_empty,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_sop,
    output logic               out_eop,
    output logic [EMPTY_W-1:0] out_empty,
    output logic               slot_free
);
    // The slot is free when empty or being drained this cycle.
    assign slot_free = ~out_valid | out_ready;

    // Valid flag: set by a load, cleared by a drain.
    always_ff @(posedge clk) begin
        if (!rst_n)          out_valid <= 1'b0;
        else if (load)       out_valid <= 1'b1;
        else if (out_ready)  out_valid <= 1'b0;
    end

    // Payload: captured only on a load, so it holds under backpressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_empty <= '0;
        end else if (load) begin
            out_data  <= d_data;
            out_sop   <= d_sop;
            out_eop   <= d_eop;
            out_empty <= d_empty;
        end
    end
endmodule

// File: rtl/byte_word_packer.sv
// Top: packs a byte stream framed by start/end markers into big-endian words
// with start/end-of-packet and an empty count, with an optional two-byte lead pad.
// Assumes each frame opens with a start byte and closes with an end byte.
module byte_word_packer #(
    parameter int BYTE_W    = pkt_pkg::BYTE_W_DEF,
    parameter int LANES     = pkt_pkg::LANES_DEF,
    parameter int PAD_LANES = pkt_pkg::PAD_LANES_DEF,
    localparam int WORD_W   = LANES * BYTE_W,
    localparam int EMPTY_W  = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pad_en,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BYTE_W-1:0]  in_data,
    input  logic               in_sof,
    input  logic               in_eof,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_sop,
    output logic               out_eop,
    output logic [EMPTY_W-1:0] out_empty
);
    logic               slot_free;
    logic               take;
    logic               push;
    logic [WORD_W-1:0]  w_data;
    logic               w_sop;
    logic               w_eop;
    logic [EMPTY_W-1:0] w_empty;

    // Bytes are taken only when a finished word could be loaded right away.
    assign in_ready = slot_free;
    assign take     = in_valid & slot_free;

    pkt_lane_asm #(.BYTE_W(BYTE_W), .LANES(LANES), .PAD_LANES(PAD_LANES)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_en  (pad_en),
        .take    (take),
        .byte_i  (in_data),
        .sof_i   (in_sof),
        .eof_i   (in_eof),
        .push    (push),
        .word_o  (w_data),
        .sop_o   (w_sop),
        .eop_o   (w_eop),
        .empty_o (w_empty)
    );

    pkt_out_reg #(.WORD_W(WORD_W), .EMPTY_W(EMPTY_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (push),
        .d_data    (w_data),
        .d_sop     (w_sop),
        .d_eop     (w_eop),
        .d_empty   (w_empty),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_empty (out_empty),
        .slot_free (slot_free)
    );
endmodule

// File: rtl/pkt_packer_chk.sv
// Checker for the packer's output protocol; attached to the top by bind.
// Assumes input frames are well formed (start byte, ..., end byte).
module pkt_packer_chk #(
    parameter int WORD_W  = 32,
    parameter int EMPTY_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [WORD_W-1:0]  out_data,
    input logic               out_sop,
    input logic               out_eop,
    input logic [EMPTY_W-1:0] out_empty
);
    logic mid_q;

    // Tracks whether the output stream is inside a packet.
    always_ff @(posedge clk) begin
        if (!rst_n)                      mid_q <= 1'b0;
        else if (out_valid && out_ready) mid_q <= ~out_eop;
    end

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)
                                   && $stable(out_eop) && $stable(out_empty));

    a_r7_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    a_r3_empty_mid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_eop |-> out_empty == '0);

    a_r2_sop_opens: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !mid_q |-> out_sop);

    a_r2_no_sop_mid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mid_q |-> !out_sop);
endmodule

bind byte_word_packer pkt_packer_chk #(.WORD_W(WORD_W), .EMPTY_W(EMPTY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_empty (out_empty)
);

// File: tb/sim_byte_word_packer.sv
// Directed bench for byte_word_packer: one task per scenario, each checks its results.
module sim_byte_word_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pad_en = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_sop;
    logic        out_eop;
    logic [1:0]  out_empty;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    int cyc = 0;

    logic [31:0] cap_d [0:63];
    logic        cap_s [0:63];
    logic        cap_e [0:63];
    logic [1:0]  cap_m [0:63];
    int          cap_n = 0;

    always #2 clk = ~clk;

    byte_word_packer u0 (
        .clk(clk), .rst_n(rst_n), .pad_en(pad_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Downstream ready pattern, changed just after each rising edge.
    initial forever begin
        @(posedge clk); #1;
        cyc++;
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = (cyc % 3) != 0;
            default: out_ready = (cyc % 11) > 6;
        endcase
    end

    // Output monitor: records handshakes, checks holding (R6) and input stall (R7).
    logic        hold_prev = 1'b0;
    logic [35:0] prev_v;
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (hold_prev)
                check(out_valid && {out_data, out_sop, out_eop, out_empty} == prev_v, "R6 hold",
                      {out_data[27:0], out_sop, out_eop, out_empty}, prev_v[31:0]);
            if (out_valid && !out_ready)
                check(!in_ready, "R7 in_ready", {31'd0, in_ready}, 32'd0);
            if (out_valid && out_ready && cap_n < 64) begin
                cap_d[cap_n] = out_data; cap_s[cap_n] = out_sop;
                cap_e[cap_n] = out_eop;  cap_m[cap_n] = out_empty;
                cap_n++;
            end
            hold_prev = out_valid && !out_ready;
            prev_v    = {out_data, out_sop, out_eop, out_empty};
        end else hold_prev = 1'b0;
    end

    // Presents one byte and returns once it has been accepted.
    task automatic send_byte(input logic [7:0] b, input logic s, input logic e);
        bit acc;
        in_valid = 1'b1; in_data = b; in_sof = s; in_eof = e;
        acc = 1'b0;
        while (!acc) begin
            @(negedge clk); acc = in_ready;
            @(posedge clk); #1;
        end
    endtask

    task automatic idle_in();
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    // Sends a frame of len bytes (values seed+k) and checks every word against the rules.
    task automatic run_frame(input int len, input bit pad, input logic [7:0] seed, input string req);
        int off, total, nw, k;
        logic [31:0] ew;
        cap_n = 0;
        pad_en = pad;
        for (int i = 0; i < len; i++) begin
            send_byte(seed + 8'(i), i == 0, i == len - 1);
            pad_en = ~pad;  // R4: only the start byte's value counts
        end
        idle_in();
        off = pad ? 2 : 0; total = len + off; nw = (total + 3) / 4;
        for (int t = 0; t < 300 && cap_n < nw; t++) @(posedge clk);
        repeat (4) @(posedge clk);
        check(cap_n == nw, {req, " word count"}, 32'(cap_n), 32'(nw));
        for (int w = 0; w < nw && w < cap_n; w++) begin
            for (int j = 0; j < 4; j++) begin
                k = 4 * w + j - off;
                ew[31 - 8*j -: 8] = (k >= 0 && k < len) ? seed + 8'(k) : 8'h00;
            end
            check(cap_d[w] == ew, {req, " data"}, cap_d[w], ew);
            check(cap_s[w] == (w == 0), {req, " sop"}, 32'(cap_s[w]), 32'(w == 0));
            check(cap_e[w] == (w == nw - 1), {req, " eop"}, 32'(cap_e[w]), 32'(w == nw - 1));
            check(cap_m[w] == ((w == nw - 1) ? 2'(4*nw - total) : 2'd0), {req, " empty"},
                  32'(cap_m[w]), (w == nw - 1) ? 32'(4*nw - total) : 32'd0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!out_valid, "R9 reset out_valid", 32'(out_valid), 32'd0);
        check(in_ready, "R9 reset in_ready", 32'(in_ready), 32'd1);
    endtask

    task automatic t_flush();  // R8
        cap_n = 0; pad_en = 1'b0; rdy_mode = 0;
        send_byte(8'hA1, 1'b1, 1'b0);
        send_byte(8'hA2, 1'b0, 1'b1);
        idle_in();
        @(negedge clk);
        check(out_valid && out_eop, "R8 flush timing", {30'd0, out_valid, out_eop}, 32'd3);
        check(out_data == 32'hA1A20000, "R8 flush data", out_data, 32'hA1A20000);
        repeat (3) @(posedge clk);
    endtask

    task automatic t_stray();  // R10
        cap_n = 0;
        send_byte(8'h55, 1'b0, 1'b0);
        send_byte(8'h66, 1'b0, 1'b0);
        send_byte(8'h77, 1'b0, 1'b1);
        idle_in();
        repeat (4) @(posedge clk);
        check(cap_n == 0, "R10 stray bytes dropped", 32'(cap_n), 32'd0);
        run_frame(5, 1'b0, 8'h40, "R10 frame after stray");
    endtask

    task automatic t_reset_mid();  // R9
        pad_en = 1'b0;
        send_byte(8'hEE, 1'b1, 1'b0);
        send_byte(8'hDD, 1'b0, 1'b0);
        send_byte(8'hCC, 1'b0, 1'b0);
        idle_in();
        rst_n = 1'b0;
        repeat (2) @(posedge clk); #1;
        @(negedge clk);
        check(!out_valid, "R9 reset mid-frame", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        run_frame(1, 1'b0, 8'h9A, "R9 frame after reset");
    endtask

    initial begin
        repeat (3) @(posedge clk); #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        run_frame(8,  1'b0, 8'h11, "R1 eight bytes");
        run_frame(64, 1'b0, 8'h00, "R2 long frame");
        run_frame(7,  1'b0, 8'h30, "R3 len7");
        run_frame(6,  1'b0, 8'h50, "R3 len6");
        run_frame(9,  1'b1, 8'h11, "R4 pad len9");
        run_frame(12, 1'b1, 8'h70, "R4 pad len12");
        run_frame(3,  1'b0, 8'hB0, "R5 len3");
        run_frame(4,  1'b0, 8'hC0, "R5 len4");
        run_frame(2,  1'b1, 8'hD0, "R5 pad len2");
        rdy_mode = 1;
        run_frame(23, 1'b0, 8'h20, "R6 periodic stall");
        rdy_mode = 2;
        run_frame(18, 1'b1, 8'h60, "R6 long stall pad");
        rdy_mode = 0;
        t_flush();
        t_stray();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule